// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block connects a requester on a big-endian bus (byte, halfword and word accesses) to a 512-byte window of peripheral registers. The registers behind the window do not all share one width. Each 4-byte group of the window has a fixed native width: 8, 16 or 32 bits, or it is unmapped. The adapter looks up that width for every request and turns the request into one or more register-side sub-accesses that use exactly the native width.

A request narrower than its register becomes an aligned native read, followed by lane selection on the way back. A narrow write becomes a read-modify-write pair that keeps the neighbouring bytes. A request wider than its register is cut into consecutive native pieces, most significant part first. Addresses past the window, unmapped groups and the illegal size code are rejected without touching the register side.

The requester raises `bus_req` and holds it, together with its address, size and data, until `bus_ready` pulses. The register side answers combinationally in the same cycle it is addressed, so each sub-access takes one clock.

Top module: `mwa_adapter`

## Requirements
- R1: The native width is looked up from address bits [8:2]. Offsets 0x000-0x02F, 0x110-0x113, 0x130-0x133 and 0x140-0x1FF are 8-bit. Offsets 0x030-0x03F, 0x100-0x10F and 0x120-0x12F are 16-bit. Offsets 0x040-0x0BF are 32-bit. Every other group is unmapped. Every sub-access uses the native width of the group that the request address falls in.
- R2: A request at address 0x200 or above, or with size code 3, is rejected. It makes no sub-access, returns `bus_rdata` = 0 with `bus_err` = 1, and changes no register.
- R3: A request that falls in an unmapped group is rejected in the same way as R2.
- R4: When the request size equals the native width, exactly one sub-access is made at the request address. It carries the request data and returns the register data unchanged.
- R5: A byte read from a 16-bit register reads the aligned halfword and returns bits [15:8] for an even address and bits [7:0] for an odd address. A byte read from a 32-bit register reads the aligned word and returns the byte at big-endian lane address[1:0].
- R6: A halfword read from a 32-bit register reads the aligned word. It returns bits [31:16] when address[1:0] is 0 and bits [15:0] otherwise.
- R7: A write narrower than its register makes two sub-accesses to the aligned native address: first a read, then a write. The write carries the old value with only the addressed lanes replaced, using the same lane choice as R5 and R6.
- R8: A request wider than its register makes (request bytes / native bytes) sub-accesses at the request address, request address + native bytes, and so on. The first piece carries or receives the most significant part.
- R9: Sub-accesses run on consecutive cycles, starting in the cycle after the request is seen. `bus_ready` is high for exactly one cycle, in the cycle after the last sub-access, or in the cycle after the request for a rejected request.
- R10: Size code 0 is a byte, 1 a halfword and 2 a word on both sides. Data is right-justified, and `bus_rdata` is zero after a write.
- R11: While `rst` is high and after it falls, with no request, `bus_ready`, `bus_err` and `reg_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Right-justified write data |
| bus_ready | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 32 | Right-justified read data, valid with `bus_ready` |
| bus_err | output | 1 | Rejected request, valid with `bus_ready` |
| reg_req | output | 1 | Register-side sub-access strobe |
| reg_we | output | 1 | Sub-access is a write |
| reg_size | output | 2 | Sub-access size code |
| reg_addr | output | 9 | Sub-access byte address in the window |
| reg_wdata | output | 32 | Sub-access write data, right-justified |
| reg_rdata | input | 32 | Register read data, same cycle as `reg_req` |

## Verification
The response arrives a fixed number of cycles after the request: n + 1 rising edges, where n is 0 for a rejection, 1 for a direct or narrow read, 2 for a read-modify-write and 2 or 4 for a split. The bench drives requests on falling edges and samples every falling edge after that. It counts the cycles until `bus_ready` and the `reg_req` cycles on the way, and compares both with n. It records the size and address of the first sub-access. It also keeps a byte-array model of the register side, so the data returned and the bytes written can be compared with a shadow copy right at the `bus_ready` sample.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

    localparam int WIN_AW = 9;
    localparam int GRP_AW = WIN_AW - 2;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        OP_DIRECT,
        OP_NARROW_RD,
        OP_RMW,
        OP_SPLIT,
        OP_REJECT
    } op_e;

    typedef struct packed {
        op_e                 op;
        logic                we;
        size_e               acc_sz;
        size_e               nat_sz;
        logic [2:0]          steps;
        logic [WIN_AW-1:0]   base;
        logic [1:0]          lane;
        logic [DATA_W-1:0]   wdata;
    } plan_t;

    // native bytes of a 4-byte group: 1, 2, 4, or 0 when unmapped
    function automatic logic [2:0] group_bytes(logic [GRP_AW-1:0] g);
        logic [WIN_AW-1:0] a;
        logic [2:0] r;
        a = {g, 2'b00};
        if (a < 9'h030)      r = 3'd1;
        else if (a < 9'h040) r = 3'd2;
        else if (a < 9'h0C0) r = 3'd4;
        else if (a < 9'h100) r = 3'd0;
        else if (a < 9'h140) begin
            if (a[4:0] < 5'h10)      r = 3'd2;
            else if (a[4:0] < 5'h14) r = 3'd1;
            else                     r = 3'd0;
        end
        else r = 3'd1;
        return r;
    endfunction

    function automatic logic [2:0] size_bytes(size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic size_e bytes_to_size(logic [2:0] b);
        case (b)
            3'd1:    return SZ_BYTE;
            3'd2:    return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // bit offset of the addressed lanes inside a right-justified native value
    function automatic logic [4:0] lane_shift(logic [1:0] lane, size_e acc, size_e nat);
        logic [4:0] s;
        if (acc == SZ_HALF)      s = (lane == 2'd0) ? 5'd16 : 5'd0;
        else if (nat == SZ_WORD) s = {2'd3 - lane, 3'b000};
        else                     s = lane[0] ? 5'd0 : 5'd8;
        return s;
    endfunction

endpackage

// File: rtl/mwa_planner.sv
module mwa_planner
    import mwa_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output plan_t             plan
);

    logic beyond;

    generate
        if (ADDR_W > WIN_AW) begin : g_wide
            assign beyond = |addr[ADDR_W-1:WIN_AW];
        end else begin : g_exact
            assign beyond = 1'b0;
        end
    endgenerate

    logic [WIN_AW-1:0] off;
    size_e             asz;
    logic [2:0]        nb;
    logic [2:0]        ab;

    assign off = addr[WIN_AW-1:0];
    assign asz = size_e'(size);

    always_comb begin
        nb          = group_bytes(off[WIN_AW-1:2]);
        ab          = size_bytes(asz);
        plan        = '0;
        plan.we     = we;
        plan.acc_sz = asz;
        plan.nat_sz = bytes_to_size(nb);
        plan.lane   = off[1:0];
        plan.wdata  = wdata;
        plan.base   = off;
        if (beyond || asz == SZ_BAD || nb == 3'd0) begin
            plan.op    = OP_REJECT;
            plan.steps = 3'd0;
        end else if (ab == nb) begin
            plan.op    = OP_DIRECT;
            plan.steps = 3'd1;
        end else if (ab < nb) begin
            plan.base  = off & ~WIN_AW'(nb - 3'd1);
            plan.op    = we ? OP_RMW : OP_NARROW_RD;
            plan.steps = we ? 3'd2 : 3'd1;
        end else begin
            plan.op    = OP_SPLIT;
            plan.steps = (nb == 3'd1) ? ab : (ab >> 1);
        end
    end

endmodule

// File: rtl/mwa_sequencer.sv
module mwa_sequencer
    import mwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  plan_t             plan,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [1:0]        reg_size,
    output logic [WIN_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

    state_e            st;
    plan_t             pl;
    logic [2:0]        step;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    logic [4:0]        sh;
    logic [DATA_W-1:0] nmask;
    logic [DATA_W-1:0] amask;
    logic [2:0]        rem;
    logic [5:0]        piece_sh;
    logic [5:0]        piece_bits;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] acc_next;
    logic              last;

    always_comb begin
        sh         = lane_shift(pl.lane, pl.acc_sz, pl.nat_sz);
        nmask      = size_mask(pl.nat_sz);
        amask      = size_mask(pl.acc_sz);
        rem        = pl.steps - 3'd1 - step;
        piece_sh   = {rem, 3'b000} << pl.nat_sz;
        piece_bits = 6'd8 << pl.nat_sz;
        data       = reg_rdata & nmask;
        acc_next   = (acc << piece_bits) | data;
        last       = (step == pl.steps - 3'd1);
    end

    // register-side drive
    always_comb begin
        reg_req  = (st == ST_RUN);
        reg_size = pl.nat_sz;
        reg_addr = pl.base;
        reg_we   = pl.we;
        case (pl.op)
            OP_RMW: begin
                reg_we    = (step == 3'd1);
                reg_wdata = ((acc & ~(amask << sh)) | ((pl.wdata & amask) << sh)) & nmask;
            end
            OP_SPLIT: begin
                reg_addr  = pl.base + (WIN_AW'(step) << pl.nat_sz);
                reg_wdata = (pl.wdata >> piece_sh) & nmask;
            end
            OP_NARROW_RD: begin
                reg_we    = 1'b0;
                reg_wdata = '0;
            end
            default: reg_wdata = pl.wdata & nmask;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            pl      <= '0;
            step    <= 3'd0;
            acc     <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (bus_req) begin
                    pl   <= plan;
                    step <= 3'd0;
                    acc  <= '0;
                    if (plan.op == OP_REJECT) begin
                        st      <= ST_DONE;
                        err_q   <= 1'b1;
                        rdata_q <= '0;
                    end else begin
                        st    <= ST_RUN;
                        err_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    case (pl.op)
                        OP_DIRECT:    rdata_q <= pl.we ? '0 : data;
                        OP_NARROW_RD: rdata_q <= (data >> sh) & amask;
                        OP_RMW: begin
                            if (step == 3'd0) acc <= data;
                            rdata_q <= '0;
                        end
                        OP_SPLIT: begin
                            acc     <= acc_next;
                            rdata_q <= pl.we ? '0 : acc_next;
                        end
                        default: rdata_q <= '0;
                    endcase
                    if (last) st <= ST_DONE;
                    else      step <= step + 3'd1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign bus_ready = (st == ST_DONE);
    assign bus_rdata = rdata_q;
    assign bus_err   = (st == ST_DONE) && err_q;

endmodule

// File: rtl/mwa_adapter.sv
module mwa_adapter
    import mwa_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              reg_req,
    output logic              reg_we,
    output logic [1:0]        reg_size,
    output logic [8:0]        reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);

    plan_t plan;

    mwa_planner #(.ADDR_W(ADDR_W)) u_plan (
        .addr  (bus_addr),
        .size  (bus_size),
        .we    (bus_we),
        .wdata (bus_wdata),
        .plan  (plan)
    );

    mwa_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .plan      (plan),
        .reg_rdata (reg_rdata),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_size  (reg_size),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

endmodule

// File: rtl/mwa_checker.sv
module mwa_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_ready,
    input logic        bus_err,
    input logic [31:0] bus_rdata,
    input logic        reg_req,
    input logic [1:0]  reg_size
);

    // R9: completion strobe lasts one cycle
    a_r9_ready_single: assert property (@(posedge clk) disable iff (rst)
        bus_ready |=> !bus_ready);

    // R9: sub-accesses run back to back up to completion
    a_r9_back_to_back: assert property (@(posedge clk) disable iff (rst)
        reg_req |=> (reg_req || bus_ready));

    // R9: no register traffic in the completion cycle
    a_r9_quiet_at_ready: assert property (@(posedge clk) disable iff (rst)
        bus_ready |-> !reg_req);

    // R2 / R3: a rejection comes with the strobe and zero data
    a_r2_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_ready && bus_rdata == 32'd0));

    // R10: register side never sees the illegal size code
    a_r10_legal_size: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> (reg_size != 2'd3));

endmodule

bind mwa_adapter mwa_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .reg_req   (reg_req),
    .reg_size  (reg_size)
);

// File: tb/tb_mwa_adapter.sv
module tb_mwa_adapter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        reg_req;
    logic        reg_we;
    logic [1:0]  reg_size;
    logic [8:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int nchecks = 0;
    int nerrs = 0;

    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];

    always #5 clk = ~clk;

    mwa_adapter dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .reg_req(reg_req), .reg_we(reg_we), .reg_size(reg_size),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // register-side model: big-endian byte array, combinational read
    always_comb begin
        case (reg_size)
            2'd0:    reg_rdata = {24'd0, mem[reg_addr]};
            2'd1:    reg_rdata = {16'd0, mem[reg_addr], mem[reg_addr + 9'd1]};
            default: reg_rdata = {mem[reg_addr], mem[reg_addr + 9'd1],
                                  mem[reg_addr + 9'd2], mem[reg_addr + 9'd3]};
        endcase
    end

    always @(posedge clk) begin
        if (reg_req && reg_we) begin
            case (reg_size)
                2'd0: mem[reg_addr] <= reg_wdata[7:0];
                2'd1: begin
                    mem[reg_addr]        <= reg_wdata[15:8];
                    mem[reg_addr + 9'd1] <= reg_wdata[7:0];
                end
                default: begin
                    mem[reg_addr]        <= reg_wdata[31:24];
                    mem[reg_addr + 9'd1] <= reg_wdata[23:16];
                    mem[reg_addr + 9'd2] <= reg_wdata[15:8];
                    mem[reg_addr + 9'd3] <= reg_wdata[7:0];
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        nchecks++;
        if (!ok) begin
            nerrs++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // native width per R1
    function automatic int tb_width(int a);
        int g;
        g = a & 'h1FC;
        if (g < 'h030) return 1;
        if (g < 'h040) return 2;
        if (g < 'h0C0) return 4;
        if (g < 'h100) return 0;
        if (g < 'h140) begin
            if ((g & 'h1F) < 'h10) return 2;
            if ((g & 'h1F) < 'h14) return 1;
            return 0;
        end
        return 1;
    endfunction

    task automatic run(input int a, input int sz, input bit w, input logic [31:0] wd);
        int b, nb, n, ea, first_exp, cyc, subs, bad;
        bit rej, done;
        string tag;
        logic [31:0] erd, rd, first_addr, first_size;
        logic er;
        b = (sz == 3) ? 0 : (1 << sz);
        rej = (a >= 512) || (sz == 3);
        nb = rej ? 0 : tb_width(a);
        if (!rej && nb == 0) begin rej = 1; tag = "R3"; end
        else if (rej) tag = "R2";
        n = 0; ea = a; first_exp = a;
        if (!rej) begin
            if (b == nb) begin n = 1; tag = "R4"; end
            else if (b < nb) begin
                n = w ? 2 : 1;
                first_exp = a & ~(nb - 1);
                tag = w ? "R7" : ((b == 1) ? "R5" : "R6");
                if (b == 2) ea = (a & ~3) + (((a & 3) == 0) ? 0 : 2);
            end else begin n = b / nb; tag = "R8"; end
        end
        erd = 0;
        if (!rej && !w)
            for (int k = 0; k < b; k++) erd = (erd << 8) | 32'(exp_mem[(ea + k) & 511]);
        if (!rej && w)
            for (int k = 0; k < b; k++) exp_mem[(ea + k) & 511] = 8'(wd >> ((b - 1 - k) * 8));

        @(negedge clk);
        bus_req = 1'b1; bus_we = w; bus_size = 2'(sz); bus_addr = 12'(a); bus_wdata = wd;
        cyc = 0; subs = 0; done = 0; first_addr = 0; first_size = 0; rd = 0; er = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (reg_req) begin
                if (subs == 0) begin first_addr = 32'(reg_addr); first_size = 32'(reg_size); end
                subs++;
            end
            if (bus_ready) begin done = 1; rd = bus_rdata; er = bus_err; end
        end
        bus_req = 1'b0;
        chk(done && cyc == n + 1, "R9", "cycles to ready", 32'(cyc), 32'(n + 1));
        chk(subs == n, tag, "sub-access count", 32'(subs), 32'(n));
        chk(er == rej, tag, "error flag", 32'(er), 32'(rej));
        if (!rej) begin
            chk((1 << first_size) == nb, "R1", "sub-access size", first_size, 32'(nb));
            chk(first_addr == 32'(first_exp), tag, "first sub-access address", first_addr, 32'(first_exp));
        end
        chk(rd == erd, w ? "R10" : tag, "read data", rd, erd);
        bad = -1;
        for (int i = 0; i < 512; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
        if (bad < 0) chk(1'b1, tag, "register contents", 0, 0);
        else chk(1'b0, tag, "register contents", 32'(mem[bad]), 32'(exp_mem[bad]));
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'((i * 7 + 3) & 255);
            exp_mem[i] = 8'((i * 7 + 3) & 255);
        end
        repeat (3) @(negedge clk);
        chk(!bus_ready && !bus_err && !reg_req, "R11", "outputs in reset", 32'({bus_ready, bus_err, reg_req}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!bus_ready && !bus_err && !reg_req, "R11", "idle after reset", 32'({bus_ready, bus_err, reg_req}), 0);

        // sweep every group, offset, size and direction inside the window
        for (int g = 0; g < 128; g++)
            for (int off = 0; off < 4; off++)
                for (int sz = 0; sz < 3; sz++)
                    for (int w = 0; w < 2; w++) begin
                        int a;
                        a = g * 4 + off;
                        if (a + (1 << sz) <= 512)
                            run(a, sz, w[0], 32'hC3A5_0000 ^ (32'(a) * 32'h0101_0101) ^ 32'(sz * 16 + w));
                    end

        // out-of-range addresses and illegal size code
        foreach (mem[i]) begin end
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                run('h200, s, w[0], 32'h1122_3344);
                run('h3FF, s, w[0], 32'h5566_7788);
                run('hFFE, s, w[0], 32'h99AA_BBCC);
            end
        run('h010, 3, 1'b1, 32'hDEAD_BEEF);
        run('h050, 3, 1'b0, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchecks++;
        nerrs++;
        $display("FAIL R9 watchdog expired: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

endmodule